// File: doc/BRIEF.md
# Packed Double-to-Int32 Converter

This block takes a 128-bit vector that holds two IEEE-754 double-precision numbers. It turns each number into a signed 32-bit integer and returns a 128-bit vector. The two integers sit in the low 64 bits and the upper 64 bits are zero. Rounding follows a 2-bit mode input. Values that cannot be represented produce the integer indefinite pattern 0x80000000 and raise an invalid flag. Results that lose fraction bits raise a precision flag.

Operations enter through a valid/ready handshake and leave one cycle later through a second valid/ready handshake. Each exception class has a mask input, where 1 means masked. If a raised flag is unmasked, the operation does not produce a valid result. Instead it gives a one-cycle exception pulse. The invalid and precision flags are reported for each operation and travel with it, so the caller can accumulate them into its own sticky status.

Top module: `f64x2_i32_cvt`

## Requirements
- R1: Source bits 63:0 convert into result bits 31:0, and source bits 127:64 convert into result bits 63:32.
- R2: On every valid output, result bits 127:64 are zero.
- R3: Rounding of inexact values follows `rmode_i`: 00 rounds to nearest with ties to even, 01 rounds toward minus infinity, 10 rounds toward plus infinity, 11 rounds toward zero.
- R4: A lane is invalid if its exponent field (bits 62:52 of the lane) is all ones (NaN or infinity), or if its rounded value is above 2147483647 or below -2147483648. An invalid lane returns 0x80000000 when the invalid exception is masked.
- R5: A lane that is not invalid and has any nonzero discarded fraction bit raises the precision flag. An invalid lane never raises the precision flag. Both output flags are the OR over the two lanes.
- R6: Zero and subnormal inputs give 0, or give +1 or -1 when the rounding mode rounds away from zero in the sign's direction. Negative zero gives 0 with no precision flag.
- R7: A mask bit of 1 masks its exception. When a raised flag has its mask at 0, `exc_o` is high for exactly one cycle with the flags, and `out_valid_o` stays low for that operation.
- R8: An input accepted at a clock edge appears on the outputs after the next edge. `in_ready_o` equals `!out_valid_o || out_ready_i`. A valid result that is not taken holds stable. After reset, `out_valid_o` and `exc_o` are low and `in_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Source vector and controls are offered |
| in_ready_o | output | 1 | Converter can accept an operation |
| src_i | input | 128 | Two packed double-precision values |
| rmode_i | input | 2 | Rounding mode |
| inv_mask_i | input | 1 | 1 masks the invalid exception |
| prec_mask_i | input | 1 | 1 masks the precision exception |
| out_valid_o | output | 1 | Result vector is valid |
| out_ready_i | input | 1 | Consumer takes the result |
| res_o | output | 128 | Two int32 results, upper 64 bits zero |
| inv_flag_o | output | 1 | Invalid raised by this operation |
| prec_flag_o | output | 1 | Precision raised by this operation |
| exc_o | output | 1 | Unmasked exception pulse for this operation |

## Verification
Two things can happen in the same cycle. An unmasked-exception pulse frees the output slot, and the next operation is accepted into that slot while the consumer holds `out_ready_i` low. The bench produces this case with random streams in which the precision mask is often cleared and back-pressure is frequent. The reference queue then expects the pulse to retire its entry without a handshake, and it expects the new entry to appear on the following cycle. A second collision inside one operation is also covered. One lane raises invalid while the other lane is inexact. The model expects both flags, with precision coming only from the valid lane.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

   typedef enum logic [1:0] {
      RM_NEAREST = 2'b00,
      RM_DOWN    = 2'b01,
      RM_UP      = 2'b10,
      RM_ZERO    = 2'b11
   } rmode_e;

   typedef struct packed {
      logic inv;
      logic inexact;
   } lane_flags_t;

endpackage

// File: rtl/f64_i32_lane.sv
module f64_i32_lane
   import cvt_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int INT_W  = 32
) (
   input  logic [EXP_W+FRAC_W:0] fp_i,
   input  rmode_e                rm_i,
   output logic [INT_W-1:0]      int_o,
   output lane_flags_t           flags_o
);

   localparam int FP_W = 1 + EXP_W + FRAC_W;
   localparam int MW   = FRAC_W + 1;        // mantissa with hidden bit
   localparam int PW   = MW + 2;            // fraction room below the point
   localparam int XW   = MW + PW;
   localparam int IW   = INT_W + 2;         // magnitude width incl. carry
   localparam int SHW  = EXP_W + 2;
   localparam int BIAS = (2 ** (EXP_W - 1)) - 1;

   localparam logic [SHW-1:0] BIG_EXP = SHW'(BIAS + INT_W + 1);
   localparam logic [SHW-1:0] SH_BASE = SHW'(BIAS + FRAC_W);
   localparam logic [SHW-1:0] SH_CAP  = SHW'(PW);
   localparam logic [IW-1:0]  NEG_LIM = {{(IW-INT_W){1'b0}}, 1'b1, {(INT_W-1){1'b0}}};
   localparam logic [IW-1:0]  POS_MAX = NEG_LIM - 1'b1;

   if (FRAC_W < INT_W + 1) begin : g_bad_frac
      $error("f64_i32_lane: FRAC_W must exceed INT_W");
   end
   if (EXP_W < 4) begin : g_bad_exp
      $error("f64_i32_lane: EXP_W too small");
   end

   logic              sgn, special, is_sub, too_big;
   logic [EXP_W-1:0]  ex;
   logic [FRAC_W-1:0] fr;
   logic [SHW-1:0]    eff_exp, sh_raw, sh;
   logic [MW-1:0]     mant;
   logic [XW-1:0]     ext;
   logic [IW-1:0]     trunc_mag, mag;
   logic              guard, sticky, inc, ovf, inv;
   logic [INT_W-1:0]  signed_res;

   assign sgn     = fp_i[FP_W-1];
   assign ex      = fp_i[FP_W-2 -: EXP_W];
   assign fr      = fp_i[FRAC_W-1:0];
   assign special = &ex;
   assign is_sub  = (ex == '0);
   assign eff_exp = is_sub ? SHW'(1) : SHW'(ex);
   assign too_big = (eff_exp >= BIG_EXP);
   assign mant    = {~is_sub, fr};

   // right shift that leaves the integer part above bit PW
   always_comb begin
      sh_raw = SH_BASE - eff_exp;
      sh     = (too_big || sh_raw > SH_CAP) ? SH_CAP : sh_raw;
      ext    = {mant, {PW{1'b0}}} >> sh;
   end

   assign trunc_mag = ext[PW +: IW];
   assign guard     = ext[PW-1];
   assign sticky    = |ext[PW-2:0];

   always_comb begin
      unique case (rm_i)
         RM_NEAREST: inc = guard & (sticky | trunc_mag[0]);
         RM_DOWN:    inc = sgn & (guard | sticky);
         RM_UP:      inc = ~sgn & (guard | sticky);
         default:    inc = 1'b0;
      endcase
   end

   assign mag        = trunc_mag + IW'(inc);
   assign ovf        = sgn ? (mag > NEG_LIM) : (mag > POS_MAX);
   assign inv        = special | too_big | ovf;
   assign signed_res = sgn ? INT_W'(-mag) : INT_W'(mag);

   assign int_o           = inv ? {1'b1, {(INT_W-1){1'b0}}} : signed_res;
   assign flags_o.inv     = inv;
   assign flags_o.inexact = ~inv & (guard | sticky);

endmodule

// File: rtl/cvt_flag_merge.sv
module cvt_flag_merge
   import cvt_pkg::*;
#(
   parameter int LANES = 2
) (
   input  lane_flags_t [LANES-1:0] flags_i,
   input  logic                    inv_mask_i,
   input  logic                    prec_mask_i,
   output logic                    inv_o,
   output logic                    prec_o,
   output logic                    unmasked_o
);

   if (LANES < 1) begin : g_bad_lanes
      $error("cvt_flag_merge: LANES must be positive");
   end

   always_comb begin
      inv_o  = 1'b0;
      prec_o = 1'b0;
      for (int i = 0; i < LANES; i++) begin
         inv_o  = inv_o  | flags_i[i].inv;
         prec_o = prec_o | flags_i[i].inexact;
      end
      unmasked_o = (inv_o & ~inv_mask_i) | (prec_o & ~prec_mask_i);
   end

endmodule

// File: rtl/cvt_out_stage.sv
module cvt_out_stage #(
   parameter int DATA_W = 128
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              inv_i,
   input  logic              prec_i,
   input  logic              exc_i,
   input  logic              out_ready_i,
   output logic              ready_o,
   output logic              out_valid_o,
   output logic              exc_o,
   output logic [DATA_W-1:0] data_o,
   output logic              inv_o,
   output logic              prec_o
);

   logic held_q, exc_q;

   assign out_valid_o = held_q & ~exc_q;
   assign exc_o       = held_q & exc_q;
   assign ready_o     = ~out_valid_o | out_ready_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         held_q <= 1'b0;
         exc_q  <= 1'b0;
         data_o <= '0;
         inv_o  <= 1'b0;
         prec_o <= 1'b0;
      end else if (load_i) begin
         held_q <= 1'b1;
         exc_q  <= exc_i;
         data_o <= data_i;
         inv_o  <= inv_i;
         prec_o <= prec_i;
      end else if (exc_o || (out_valid_o && out_ready_i)) begin
         held_q <= 1'b0;
         exc_q  <= 1'b0;
      end
   end

   // R8
   stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o && !out_ready_i |=> out_valid_o && $stable(data_o));

   // R7
   exc_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exc_o && !load_i |=> !exc_o);

endmodule

// File: rtl/f64x2_i32_cvt.sv
module f64x2_i32_cvt
   import cvt_pkg::*;
#(
   parameter int LANES  = 2,
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int INT_W  = 32,
   parameter int VEC_W  = 128
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             in_valid_i,
   output logic             in_ready_o,
   input  logic [VEC_W-1:0] src_i,
   input  logic [1:0]       rmode_i,
   input  logic             inv_mask_i,
   input  logic             prec_mask_i,
   output logic             out_valid_o,
   input  logic             out_ready_i,
   output logic [VEC_W-1:0] res_o,
   output logic             inv_flag_o,
   output logic             prec_flag_o,
   output logic             exc_o
);

   localparam int FP_W   = 1 + EXP_W + FRAC_W;
   localparam int PACK_W = LANES * INT_W;

   if (VEC_W != LANES * FP_W) begin : g_bad_vec
      $error("f64x2_i32_cvt: VEC_W must hold LANES floating values");
   end
   if (PACK_W > VEC_W) begin : g_bad_pack
      $error("f64x2_i32_cvt: packed integers exceed VEC_W");
   end

   logic [LANES-1:0][INT_W-1:0] lane_int;
   lane_flags_t [LANES-1:0]     lane_flg;
   logic [PACK_W-1:0]           packed_res;
   logic [VEC_W-1:0]            next_vec;
   logic                        any_inv, any_prec, unmasked;
   logic                        in_fire;
   rmode_e                      rm;

   assign rm      = rmode_e'(rmode_i);
   assign in_fire = in_valid_i & in_ready_o;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      f64_i32_lane #(
         .EXP_W (EXP_W),
         .FRAC_W(FRAC_W),
         .INT_W (INT_W)
      ) u_lane (
         .fp_i   (src_i[g*FP_W +: FP_W]),
         .rm_i   (rm),
         .int_o  (lane_int[g]),
         .flags_o(lane_flg[g])
      );

      // R4
      pos_lane_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         in_fire && !src_i[g*FP_W + FP_W - 1] && !lane_flg[g].inv
            |-> !lane_int[g][INT_W-1]);
   end

   assign packed_res = lane_int;

   if (VEC_W > PACK_W) begin : g_zero_fill
      assign next_vec = {{(VEC_W-PACK_W){1'b0}}, packed_res};
   end else begin : g_full
      assign next_vec = packed_res;
   end

   cvt_flag_merge #(.LANES(LANES)) u_merge (
      .flags_i    (lane_flg),
      .inv_mask_i (inv_mask_i),
      .prec_mask_i(prec_mask_i),
      .inv_o      (any_inv),
      .prec_o     (any_prec),
      .unmasked_o (unmasked)
   );

   cvt_out_stage #(.DATA_W(VEC_W)) u_out (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (in_fire),
      .data_i     (next_vec),
      .inv_i      (any_inv),
      .prec_i     (any_prec),
      .exc_i      (unmasked),
      .out_ready_i(out_ready_i),
      .ready_o    (in_ready_o),
      .out_valid_o(out_valid_o),
      .exc_o      (exc_o),
      .data_o     (res_o),
      .inv_o      (inv_flag_o),
      .prec_o     (prec_flag_o)
   );

   // R8
   one_cycle_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_fire |=> out_valid_o || exc_o);

   // R7
   unmasked_to_exc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_fire && unmasked |=> exc_o && !out_valid_o);

endmodule

// File: tb/test_f64x2_i32_cvt.sv
`timescale 1ns/1ps
module test_f64x2_i32_cvt;

   typedef struct {
      logic [127:0] res;
      bit           inv;
      bit           px;
      bit           exc;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [127:0] src = '0;
   logic [1:0]   rmode = 2'b00;
   logic         inv_mask = 1'b1;
   logic         prec_mask = 1'b1;
   logic         out_ready = 1'b0;
   logic         in_ready, out_valid, inv_flag, prec_flag, exc;
   logic [127:0] res;

   int   n_tests = 0;
   int   n_fail  = 0;
   exp_t q[$];

   always #2.5 clk = ~clk;

   f64x2_i32_cvt i_f64x2_i32_cvt (
      .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
      .src_i(src), .rmode_i(rmode), .inv_mask_i(inv_mask), .prec_mask_i(prec_mask),
      .out_valid_o(out_valid), .out_ready_i(out_ready), .res_o(res),
      .inv_flag_o(inv_flag), .prec_flag_o(prec_flag), .exc_o(exc)
   );

   task automatic check(input bit ok, input string what, input logic [127:0] act,
                        input logic [127:0] expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", what, act, expv);
      end
   endtask

   // reference conversion of one lane, built from the requirement text
   function automatic void ref_lane(input logic [63:0] b, input logic [1:0] rm,
                                    output logic [31:0] r, output bit inv, output bit px);
      real    v, a, fr;
      longint t, qv;
      inv = 0; px = 0; r = '0;
      if (b[62:52] == 11'h7ff) inv = 1;
      else begin
         v = $bitstoreal(b);
         a = (v < 0.0) ? -v : v;
         if (a >= 4.0e9) inv = 1;
         else begin
            t = longint'(v);
            if (v >= 0.0 && real'(t) > v) t--;
            if (v < 0.0 && real'(t) < v) t++;
            fr = v - real'(t);
            px = (fr != 0.0);
            qv = t;
            case (rm)
               2'b00: begin
                  if (fr > 0.5) qv = t + 1;
                  else if (fr < -0.5) qv = t - 1;
                  else if (fr == 0.5 && (t % 2) != 0) qv = t + 1;
                  else if (fr == -0.5 && (t % 2) != 0) qv = t - 1;
               end
               2'b01: if (fr < 0.0) qv = t - 1;
               2'b10: if (fr > 0.0) qv = t + 1;
               default: qv = t;
            endcase
            if (qv > 64'sd2147483647 || qv < -64'sd2147483648) inv = 1;
            else r = qv[31:0];
         end
      end
      if (inv) begin
         r = 32'h8000_0000;
         px = 0;
      end
   endfunction

   function automatic exp_t ref_op(input logic [127:0] s, input logic [1:0] rm,
                                   input bit im, input bit pm);
      exp_t e;
      logic [31:0] r0, r1;
      bit i0, i1, p0, p1;
      ref_lane(s[63:0], rm, r0, i0, p0);
      ref_lane(s[127:64], rm, r1, i1, p1);
      e.res = {64'h0, r1, r0};
      e.inv = i0 | i1;
      e.px  = p0 | p1;
      e.exc = (e.inv & !im) | (e.px & !pm);
      return e;
   endfunction

   // compare outputs against the head of the reference queue
   task automatic compare_outputs();
      exp_t e;
      if (q.size() == 0) begin
         check(!out_valid && !exc, "R8 output without accepted input",
               {126'h0, out_valid, exc}, 128'h0);
         return;
      end
      e = q[0];
      check(out_valid || exc, "R8 latency: accepted op not presented",
            {126'h0, out_valid, exc}, 128'h1);
      check(exc == e.exc && out_valid == !e.exc, "R7 exception vs valid",
            {126'h0, out_valid, exc}, {126'h0, !e.exc, e.exc});
      check(inv_flag == e.inv && prec_flag == e.px, "R4,R5 flags",
            {126'h0, inv_flag, prec_flag}, {126'h0, e.inv, e.px});
      if (!e.exc) begin
         check(res[127:64] == 64'h0, "R2 upper half zero", res, e.res);
         check(res[63:0] == e.res[63:0], "R1,R3,R4,R6 lane results", res, e.res);
      end
   endtask

   task automatic cycle(input bit v, input logic [127:0] s, input logic [1:0] rm,
                        input bit im, input bit pm, input bit rdy);
      @(negedge clk);
      compare_outputs();
      in_valid  = v;
      src       = s;
      rmode     = rm;
      inv_mask  = im;
      prec_mask = pm;
      out_ready = rdy;
      #0.5;
      check(in_ready == (!out_valid || out_ready), "R8 ready rule",
            {127'h0, in_ready}, {127'h0, (!out_valid || out_ready)});
      if (q.size() > 0 && (exc || (out_valid && out_ready))) void'(q.pop_front());
      if (in_valid && in_ready) q.push_back(ref_op(src, rmode, inv_mask, prec_mask));
   endtask

   function automatic logic [63:0] rnd_dbl();
      logic [63:0] b;
      int sel = $urandom % 8;
      b = {$urandom, $urandom};
      case (sel)
         0: b[62:52] = 11'h7ff;
         1: begin b[62:52] = 11'h000; if ($urandom % 2) b[51:0] = '0; end
         2: b = $realtobits(((($urandom % 2) != 0) ? -1.0 : 1.0) *
                            (2147483646.0 + real'($urandom % 6) * 0.5));
         3: b = $realtobits(((($urandom % 2) != 0) ? -1.0 : 1.0) *
                            (real'($urandom % 64) * 0.5));
         4: b[62:52] = 11'd1023 + 11'($urandom % 36);
         default: b[62:52] = 11'd1000 + 11'($urandom % 58);
      endcase
      return b;
   endfunction

   logic [63:0] dir [16];

   initial begin
      dir[0]  = $realtobits(1.5);
      dir[1]  = $realtobits(2.5);
      dir[2]  = $realtobits(-2.5);
      dir[3]  = $realtobits(-1.25);
      dir[4]  = $realtobits(2147483647.0);
      dir[5]  = $realtobits(2147483647.5);
      dir[6]  = $realtobits(-2147483648.0);
      dir[7]  = $realtobits(-2147483648.5);
      dir[8]  = 64'h7ff8_0000_0000_0000;   // NaN
      dir[9]  = 64'hfff0_0000_0000_0000;   // -inf
      dir[10] = 64'h0000_0000_0000_0001;   // + subnormal
      dir[11] = 64'h8000_0000_0000_0001;   // - subnormal
      dir[12] = 64'h8000_0000_0000_0000;   // -0
      dir[13] = $realtobits(1.0e20);
      dir[14] = $realtobits(123456.75);
      dir[15] = $realtobits(-7.0);

      repeat (3) @(negedge clk);
      #0.5;
      // R8 reset state
      check(!out_valid && !exc && in_ready, "R8 reset state",
            {125'h0, out_valid, exc, in_ready}, 128'h1);
      rst_n = 1'b1;

      // directed: every value in both lanes, all modes, masked
      for (int m = 0; m < 4; m++)
         for (int i = 0; i < 16; i++)
            cycle(1, {dir[(i + 5) % 16], dir[i]}, 2'(m), 1, 1, 1);

      // R7: unmasked invalid and unmasked precision, with a stalled consumer
      cycle(1, {$realtobits(3.0), dir[8]}, 2'b00, 0, 1, 0);
      cycle(1, {$realtobits(3.0), $realtobits(0.5)}, 2'b10, 1, 0, 0);
      cycle(1, {$realtobits(4.0), $realtobits(9.0)}, 2'b00, 0, 0, 0);
      cycle(0, '0, 2'b00, 1, 1, 0);
      cycle(0, '0, 2'b00, 1, 1, 1);

      // random stream with back-pressure and mixed masks
      for (int k = 0; k < 6000; k++)
         cycle(($urandom % 5) != 0, {rnd_dbl(), rnd_dbl()}, 2'($urandom % 4),
               ($urandom % 4) != 0, ($urandom % 3) != 0, ($urandom % 10) < 6);

      repeat (4) cycle(0, '0, 2'b00, 1, 1, 1);
      check(q.size() == 0, "R8 queue drained", 128'(q.size()), 128'h0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule